// File: doc/BRIEF.md
# Transceiver Management Control Register

This block provides register 0, the control register, of a fixed-speed, full-duplex gigabit transceiver channel. It also includes the serial management frame decoder that reaches it. The block runs entirely on the management clock. It samples the data line on each rising edge and changes its own driven data after that edge. The data line is split into an input, an output and an output enable, so a pad tristate can be built from them.

The control register has four live fields:
- a self-clearing soft reset;
- loopback enable;
- auto-negotiation enable;
- a self-clearing restart of auto-negotiation.

Every other bit is fixed and reports 1000 Mb/s full duplex. The loopback and auto-negotiation fields take their power-up values from two strap inputs. A soft reset reloads them from the straps as they are at that moment.

The decoder is a state machine with these states:
- `ST_SYNC` counts consecutive ones. After at least 32 ones, a zero moves it to `ST_START`.
- `ST_START` goes to `ST_OPCODE` on a one and back to `ST_SYNC` on a zero.
- `ST_OPCODE` takes two bits. It goes to `ST_PHYAD` on a read (10) or a write (01), and to `ST_SYNC` on any other code.
- `ST_PHYAD` takes 5 bits and then goes to `ST_REGAD`.
- `ST_REGAD` takes 5 bits. It then goes to `ST_TA_RD` for a read or `ST_TA_WR` for a write.
- Each turnaround state takes two bits. It then goes to `ST_RDATA` or `ST_WDATA`.
- Each data state takes 16 bits and then returns to `ST_SYNC`.

Top module: `phy_mgmt_ctrl`

## Requirements
- R1: While `rst_n` is low, `loop_en` follows `strap_loop` and `aneg_en` follows `strap_aneg`. After reset, register 0 reads with bit 15 = 0, bit 14 = loopback, bit 12 = auto-negotiation enable and bit 9 = 0. `soft_rst` and `aneg_restart` are low.
- R2: A write to register 0 without bit 15 set loads bit 14 into `loop_en` and bit 12 into `aneg_en`. The update happens on the MDC rising edge after the edge that samples the last data bit. Without such a write, both values hold.
- R3: In a register 0 read, bits 8 and 6 are always 1. Bits 13, 11, 10, 7 and 5..0 are always 0. Writes to any of these bits have no effect.
- R4: A write to register 0 with bit 15 set raises `soft_rst` for exactly one MDC cycle and reloads `loop_en` and `aneg_en` from the current strap inputs. All other bits of that write are ignored, and no restart pulse is produced.
- R5: A write to register 0 with bit 9 set and bit 15 clear raises `aneg_restart` for exactly one MDC cycle. Bit 9 then reads 0.
- R6: A frame is 32 or more preamble ones, then start 01, opcode, 5-bit PHY address and 5-bit register address, all MSB first. Opcode 10 is a read and 01 is a write. Opcodes 00 and 11 end the frame with no drive and no write.
- R7: During a read, `mdio_oe` is low for both turnaround bits. It is high for exactly 16 bit times, starting after the rising edge that samples the second turnaround bit. Data goes out MSB first, and `mdio_oe` is low again after the frame.
- R8: A frame whose PHY address differs from `phy_addr` never raises `mdio_oe` and changes no state.
- R9: A read of any register address other than 0 returns 16 zero bits. A write to any such address changes nothing.
- R10: A start pattern preceded by fewer than 32 consecutive ones is not recognised, and the frame after it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low device reset |
| phy_addr | input | 5 | PHY address this channel answers to |
| strap_loop | input | 1 | Loopback default value |
| strap_aneg | input | 1 | Auto-negotiation enable default value |
| mdio_in | input | 1 | Management data line, input side |
| mdio_out | output | 1 | Management data line, output value |
| mdio_oe | output | 1 | Drive enable for the management data line |
| loop_en | output | 1 | Digital loopback enable (register bit 14) |
| aneg_en | output | 1 | Auto-negotiation enable (register bit 12) |
| aneg_restart | output | 1 | One-cycle restart auto-negotiation pulse |
| soft_rst | output | 1 | One-cycle soft reset pulse for the management registers |

## Verification
The hardest case to reach from the ports is a soft reset that picks up strap values different from the ones present at power-up. The bench first clears the loopback field with an ordinary write and then flips the straps, confirming that nothing changes. Only then does it write bit 15, so a reload from the power-up values would read differently from a reload from the current straps. Rejection of a short preamble and of bad opcodes is also reached only by deliberately malformed frames. Each such frame carries a write that would visibly change `loop_en`, and each is followed by a correct frame to prove that the decoder has resynchronised.

// File: rtl/mdio_ctl_pkg.sv
package mdio_ctl_pkg;

    localparam int unsigned DATA_W  = 16;
    localparam int unsigned ADDR_W  = 5;
    localparam int unsigned PRE_LEN = 32;

    // Register address of the control word and its live bit positions
    localparam logic [ADDR_W-1:0] CTRL_REGAD = '0;
    localparam int unsigned B_SRST    = 15;
    localparam int unsigned B_LOOP    = 14;
    localparam int unsigned B_ANEG    = 12;
    localparam int unsigned B_RESTART = 9;
    localparam int unsigned B_DUPLEX  = 8;
    localparam int unsigned B_SPD_MSB = 6;

    typedef enum logic [3:0] {
        ST_SYNC,
        ST_START,
        ST_OPCODE,
        ST_PHYAD,
        ST_REGAD,
        ST_TA_RD,
        ST_RDATA,
        ST_TA_WR,
        ST_WDATA
    } mf_state_e;

endpackage

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_ctl_pkg::*;
#(
    parameter int unsigned DW   = DATA_W,
    parameter int unsigned AW   = ADDR_W,
    parameter int unsigned PREN = PRE_LEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mdio_in,
    input  logic [AW-1:0] phy_addr,
    input  logic [DW-1:0] rd_word,
    output logic [AW-1:0] regad,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          mdio_out,
    output logic          mdio_oe
);

    localparam int unsigned CMAX = (PREN > DW) ? PREN : DW;
    localparam int unsigned CNT_W = $clog2(CMAX + 1);
    localparam logic [CNT_W-1:0] PRE_MAX = CNT_W'(PREN);
    localparam logic [CNT_W-1:0] LAST_AW = CNT_W'(AW - 1);
    localparam logic [CNT_W-1:0] LAST_DW = CNT_W'(DW - 1);
    localparam logic [CNT_W-1:0] LAST_2  = CNT_W'(1);

    mf_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [DW-1:0]    shreg_q;
    logic             is_read_q;
    logic             match_q;
    logic [AW-1:0]    regad_q;
    logic             wr_en_q;
    logic [DW-1:0]    wr_data_q;
    logic [1:0]       op_bits;
    logic [AW-1:0]    addr_bits;

    assign op_bits   = {shreg_q[0], mdio_in};
    assign addr_bits = {shreg_q[AW-2:0], mdio_in};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SYNC;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SYNC:   if (!mdio_in && cnt_q == PRE_MAX) state_d = ST_START;
            ST_START:  state_d = mdio_in ? ST_OPCODE : ST_SYNC;
            ST_OPCODE: if (cnt_q == LAST_2)
                           state_d = (op_bits == 2'b10 || op_bits == 2'b01) ? ST_PHYAD : ST_SYNC;
            ST_PHYAD:  if (cnt_q == LAST_AW) state_d = ST_REGAD;
            ST_REGAD:  if (cnt_q == LAST_AW) state_d = is_read_q ? ST_TA_RD : ST_TA_WR;
            ST_TA_RD:  if (cnt_q == LAST_2)  state_d = ST_RDATA;
            ST_TA_WR:  if (cnt_q == LAST_2)  state_d = ST_WDATA;
            ST_RDATA:  if (cnt_q == LAST_DW) state_d = ST_SYNC;
            ST_WDATA:  if (cnt_q == LAST_DW) state_d = ST_SYNC;
            default:   state_d = ST_SYNC;
        endcase
    end

    // Datapath: counters, shifter, captured fields and write strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            shreg_q   <= '0;
            is_read_q <= 1'b0;
            match_q   <= 1'b0;
            regad_q   <= '0;
            wr_en_q   <= 1'b0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (state_q == ST_SYNC) begin
                if (!mdio_in)              cnt_q <= '0;
                else if (cnt_q != PRE_MAX) cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end

            unique case (state_q)
                ST_OPCODE: begin
                    shreg_q <= {shreg_q[DW-2:0], mdio_in};
                    if (cnt_q == LAST_2) is_read_q <= (op_bits == 2'b10);
                end
                ST_PHYAD: begin
                    shreg_q <= {shreg_q[DW-2:0], mdio_in};
                    if (cnt_q == LAST_AW) match_q <= (addr_bits == phy_addr);
                end
                ST_REGAD: begin
                    shreg_q <= {shreg_q[DW-2:0], mdio_in};
                    if (cnt_q == LAST_AW) regad_q <= addr_bits;
                end
                ST_TA_RD: if (cnt_q == LAST_2) shreg_q <= rd_word;
                ST_RDATA: shreg_q <= {shreg_q[DW-2:0], 1'b0};
                ST_WDATA: begin
                    shreg_q <= {shreg_q[DW-2:0], mdio_in};
                    if (cnt_q == LAST_DW) begin
                        wr_en_q   <= match_q;
                        wr_data_q <= {shreg_q[DW-2:0], mdio_in};
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mdio_oe  = (state_q == ST_RDATA) && match_q;
        mdio_out = mdio_oe ? shreg_q[DW-1] : 1'b0;
        regad    = regad_q;
        wr_en    = wr_en_q;
        wr_data  = wr_data_q;
    end

    p_start_after_preamble_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START) |-> ($past(cnt_q) == PRE_MAX));

    p_write_from_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_q |-> ($past(state_q) == ST_WDATA));

    p_drive_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> ($past(state_q) == ST_TA_RD || $past(state_q) == ST_RDATA));

endmodule

// File: rtl/mgmt_ctrl_core.sv
module mgmt_ctrl_core
    import mdio_ctl_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_loop,
    input  logic          strap_aneg,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] ctrl_word,
    output logic          loop_en,
    output logic          aneg_en,
    output logic          soft_rst,
    output logic          aneg_restart
);

    logic loop_q, aneg_q, srst_q, rstrt_q;
    logic unused_wdata;

    assign unused_wdata = ^wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loop_q  <= strap_loop;
            aneg_q  <= strap_aneg;
            srst_q  <= 1'b0;
            rstrt_q <= 1'b0;
        end else begin
            srst_q  <= 1'b0;
            rstrt_q <= 1'b0;
            if (wr_en) begin
                if (wr_data[B_SRST]) begin
                    srst_q <= 1'b1;
                    loop_q <= strap_loop;
                    aneg_q <= strap_aneg;
                end else begin
                    loop_q  <= wr_data[B_LOOP];
                    aneg_q  <= wr_data[B_ANEG];
                    rstrt_q <= wr_data[B_RESTART];
                end
            end
        end
    end

    always_comb begin
        ctrl_word            = '0;
        ctrl_word[B_SRST]    = srst_q;
        ctrl_word[B_LOOP]    = loop_q;
        ctrl_word[B_ANEG]    = aneg_q;
        ctrl_word[B_RESTART] = rstrt_q;
        ctrl_word[B_DUPLEX]  = 1'b1;
        ctrl_word[B_SPD_MSB] = 1'b1;
        loop_en      = loop_q;
        aneg_en      = aneg_q;
        soft_rst     = srst_q;
        aneg_restart = rstrt_q;
    end

    p_srst_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

    p_srst_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (loop_en == $past(strap_loop)) && (aneg_en == $past(strap_aneg)));

    p_restart_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        aneg_restart |=> !aneg_restart);

    p_no_restart_in_srst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> !aneg_restart);

endmodule

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
    import mdio_ctl_pkg::*;
(
    input  logic              mdc,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              strap_loop,
    input  logic              strap_aneg,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              loop_en,
    output logic              aneg_en,
    output logic              aneg_restart,
    output logic              soft_rst
);

    logic [ADDR_W-1:0] regad;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] rd_word;
    logic              ctrl_sel;

    assign ctrl_sel = (regad == CTRL_REGAD);
    assign rd_word  = ctrl_sel ? ctrl_word : '0;

    mdio_frame_fsm #(
        .DW  (DATA_W),
        .AW  (ADDR_W),
        .PREN(PRE_LEN)
    ) u_fsm (
        .clk     (mdc),
        .rst_n   (rst_n),
        .mdio_in (mdio_in),
        .phy_addr(phy_addr),
        .rd_word (rd_word),
        .regad   (regad),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .mdio_out(mdio_out),
        .mdio_oe (mdio_oe)
    );

    mgmt_ctrl_core #(
        .DW(DATA_W)
    ) u_core (
        .clk         (mdc),
        .rst_n       (rst_n),
        .strap_loop  (strap_loop),
        .strap_aneg  (strap_aneg),
        .wr_en       (wr_en && ctrl_sel),
        .wr_data     (wr_data),
        .ctrl_word   (ctrl_word),
        .loop_en     (loop_en),
        .aneg_en     (aneg_en),
        .soft_rst    (soft_rst),
        .aneg_restart(aneg_restart)
    );

    p_other_reg_no_effect_r9: assert property (@(posedge mdc) disable iff (!rst_n)
        ($past(wr_en) && !$past(ctrl_sel)) |-> ($stable(loop_en) && $stable(aneg_en)));

endmodule

// File: tb/phy_mgmt_ctrl_test.sv
module phy_mgmt_ctrl_test;

    logic       mdc = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] phy_addr = 5'd9;
    logic       strap_loop = 1'b0;
    logic       strap_aneg = 1'b0;
    logic       mdio_in = 1'b1;
    logic       mdio_out, mdio_oe, loop_en, aneg_en, aneg_restart, soft_rst;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    phy_mgmt_ctrl uut (
        .mdc(mdc), .rst_n(rst_n), .phy_addr(phy_addr),
        .strap_loop(strap_loop), .strap_aneg(strap_aneg),
        .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .loop_en(loop_en), .aneg_en(aneg_en),
        .aneg_restart(aneg_restart), .soft_rst(soft_rst)
    );

    always #5 mdc = ~mdc;

    function automatic logic [15:0] exp_word(input logic l, input logic a);
        return 16'h0140 | (16'(l) << 14) | (16'(a) << 12);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        @(negedge mdc);
        mdio_in = b;
        @(posedge mdc);
    endtask

    task automatic header(input int npre, input logic [1:0] op,
                          input logic [4:0] pa, input logic [4:0] ra);
        repeat (npre) bit_out(1'b1);
        bit_out(1'b0);
        bit_out(1'b1);
        for (int i = 1; i >= 0; i--) bit_out(op[i]);
        for (int i = 4; i >= 0; i--) bit_out(pa[i]);
        for (int i = 4; i >= 0; i--) bit_out(ra[i]);
    endtask

    task automatic do_write(input int npre, input logic [1:0] op, input logic [4:0] pa,
                            input logic [4:0] ra, input logic [15:0] d);
        header(npre, op, pa, ra);
        bit_out(1'b1);
        bit_out(1'b0);
        for (int i = 15; i >= 0; i--) bit_out(d[i]);
    endtask

    task automatic do_read(input logic [4:0] pa, input logic [4:0] ra,
                           output logic [15:0] val, output int drv, output int stray);
        val = '0;
        drv = 0;
        stray = 0;
        header(32, 2'b10, pa, ra);
        for (int i = 0; i < 2; i++) begin
            @(negedge mdc);
            if (mdio_oe) stray++;
            mdio_in = 1'b1;
            @(posedge mdc);
        end
        for (int i = 15; i >= 0; i--) begin
            @(negedge mdc);
            val[i] = mdio_out;
            if (mdio_oe) drv++;
            @(posedge mdc);
        end
        @(negedge mdc);
        if (mdio_oe) stray++;
    endtask

    task automatic do_reset(input logic sl, input logic sa);
        @(negedge mdc);
        rst_n = 1'b0;
        strap_loop = sl;
        strap_aneg = sa;
        mdio_in = 1'b1;
        repeat (3) @(posedge mdc);
        @(negedge mdc);
        rst_n = 1'b1;
    endtask

    function automatic logic [15:0] pattern(input int k);
        if (k < 16) return 16'h0001 << k;
        case (k)
            16: return 16'hFFFF;
            17: return 16'h7FFF;
            18: return 16'h5A5A;
            19: return 16'h0000;
            20: return 16'h5200;
            default: return 16'h1000;
        endcase
    endfunction

    initial begin
        #2_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int drv, stray;
        logic el, ea;

        // R1, R3, R7: reset values from every strap combination
        for (int s = 0; s < 4; s++) begin
            do_reset(s[1], s[0]);
            #2;
            chk("R1 loop_en", 16'(loop_en), 16'(s[1]));
            chk("R1 aneg_en", 16'(aneg_en), 16'(s[0]));
            chk("R1 pulses", {14'd0, soft_rst, aneg_restart}, 16'd0);
            do_read(5'd9, 5'd0, v, drv, stray);
            chk("R1 R3 read", v, exp_word(s[1], s[0]));
            chk("R7 drive count", 16'(drv), 16'd16);
            chk("R7 turnaround release", 16'(stray), 16'd0);
        end

        // R2, R3, R4, R5: write sweep with both straps high
        do_reset(1'b1, 1'b1);
        for (int k = 0; k < 21; k++) begin
            v = pattern(k);
            do_write(32, 2'b01, 5'd9, 5'd0, v);
            el = v[15] ? 1'b1 : v[14];
            ea = v[15] ? 1'b1 : v[12];
            @(posedge mdc);
            #2;
            chk("R4 soft_rst pulse", 16'(soft_rst), 16'(v[15]));
            chk("R5 restart pulse", 16'(aneg_restart), 16'(v[9] && !v[15]));
            chk("R2 loop_en", 16'(loop_en), 16'(el));
            chk("R2 aneg_en", 16'(aneg_en), 16'(ea));
            @(posedge mdc);
            #2;
            chk("R4 R5 pulses single", {14'd0, soft_rst, aneg_restart}, 16'd0);
            do_read(5'd9, 5'd0, v, drv, stray);
            chk("R3 R5 readback", v, exp_word(el, ea));
        end

        // R4: reload from straps as they are now
        do_write(32, 2'b01, 5'd9, 5'd0, 16'h0000);
        @(negedge mdc);
        strap_loop = 1'b1;
        strap_aneg = 1'b0;
        repeat (3) @(posedge mdc);
        #2;
        chk("R2 straps ignored", {14'd0, loop_en, aneg_en}, 16'd0);
        do_write(32, 2'b01, 5'd9, 5'd0, 16'h9200);
        @(posedge mdc);
        #2;
        chk("R4 reload current straps", {14'd0, loop_en, aneg_en}, 16'b10);
        chk("R4 no restart", 16'(aneg_restart), 16'd0);

        // R8: every foreign PHY address is ignored
        do_write(32, 2'b01, 5'd9, 5'd0, 16'h0000);
        for (int pa = 0; pa < 32; pa++) begin
            if (pa == 9) continue;
            do_write(32, 2'b01, 5'(pa), 5'd0, 16'h5200);
            @(posedge mdc);
            #2;
            chk("R8 foreign write", {13'd0, loop_en, aneg_en, aneg_restart}, 16'd0);
            do_read(5'(pa), 5'd0, v, drv, stray);
            chk("R8 foreign read drive", 16'(drv + stray), 16'd0);
        end

        // R9: other register addresses
        for (int ra = 1; ra < 32; ra++) begin
            do_write(32, 2'b01, 5'd9, 5'(ra), 16'h5200);
            @(posedge mdc);
            #2;
            chk("R9 other write", {13'd0, loop_en, aneg_en, aneg_restart}, 16'd0);
            do_read(5'd9, 5'(ra), v, drv, stray);
            chk("R9 other read", v, 16'h0000);
            chk("R9 other drive", 16'(drv), 16'd16);
        end

        // R6: bad opcodes
        do_write(32, 2'b11, 5'd9, 5'd0, 16'h5000);
        do_write(32, 2'b00, 5'd9, 5'd0, 16'h5000);
        @(posedge mdc);
        #2;
        chk("R6 bad opcode ignored", {14'd0, loop_en, aneg_en}, 16'd0);

        // R10: short preamble, then a good frame
        do_write(31, 2'b01, 5'd9, 5'd0, 16'h5000);
        @(posedge mdc);
        #2;
        chk("R10 short preamble ignored", {14'd0, loop_en, aneg_en}, 16'd0);
        do_write(32, 2'b01, 5'd9, 5'd0, 16'h4000);
        @(posedge mdc);
        #2;
        chk("R6 R10 resync write", {14'd0, loop_en, aneg_en}, 16'b10);
        do_read(5'd9, 5'd0, v, drv, stray);
        chk("R6 resync read", v, exp_word(1'b1, 1'b0));

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule